// File: doc/BRIEF.md
# PCI Configuration Address/Data Port Bridge

This block sits at the front of a host bridge. It turns processor I/O-port reads and writes into PCI configuration requests through an indirect window. Software first writes a 32-bit configuration address register. That register holds an enable flag and the bus, device, function and dword index of the target. Software then reads or writes a four-byte data window. Each window access that is legal while enable is set becomes exactly one configuration request on a valid/ready interface. The bridge returns the responder's read data to the I/O side, aligned to the low end.

The low two bits of the I/O address inside the window select the starting byte lane. The access size of 1, 2 or 4 bytes selects how many lanes are used. The bridge refuses accesses whose size is illegal or whose lane is not aligned to the size. It also refuses all window accesses while enable is clear. A refused read returns all ones, and a refused write is dropped. Each I/O access is a one-cycle `io_req` pulse and is answered by a one-cycle `io_ack`. A pulse that arrives while a configuration request is still outstanding is ignored.

Top module: `pci_cfg_port_bridge`

## Requirements
- R1: After reset, `io_ack` and `cfg_valid` are low and the address register reads as 0x00000000.
- R2: A 4-byte write to I/O address 0x0CF8 stores all 32 bits of `io_wdata`, including bits 1:0. A 4-byte read there returns the stored value. In both cases `io_ack` is high in the cycle after the request.
- R3: A window access (0x0CFC to 0x0CFF) that is legal and arrives while address bit 31 is set raises `cfg_valid` in the cycle after the request. The request carries bus = bits 23:16, device = bits 15:11, function = bits 10:8 and dword index = bits 7:2 of the address register. Bits 1:0 of the register are not used. All request fields are held stable until `cfg_ready` is seen.
- R4: `cfg_be` is the size mask (1 byte = 4'b0001, 2 bytes = 4'b0011, 4 bytes = 4'b1111) shifted left by the lane `io_addr[1:0]`. `cfg_wdata` is `io_wdata` shifted left by 8 times the lane, with bits shifted past bit 31 dropped.
- R5: In the cycle after `cfg_valid && cfg_ready`, `io_ack` is high and `cfg_valid` is low. For a read, `io_rdata` is `cfg_rdata` shifted right by 8 times the lane, with the bytes beyond the access size forced to zero.
- R6: A window access with a size other than 1, 2 or 4 raises no request. So does an access whose lane is not a multiple of its size (2 bytes at an odd lane, 4 bytes at a nonzero lane). Such a read is acknowledged next cycle with 0xFFFFFFFF.
- R7: While address bit 31 is clear, for example after writing zero to the register, window reads are acknowledged next cycle with 0xFFFFFFFF. Window writes are acknowledged and discarded, and no request is raised.
- R8: An `io_req` that arrives while `cfg_valid` is high is ignored. It produces no acknowledge of its own and does not change the address register.
- R9: An all-ones response, such as from an absent device, reaches the I/O side as ones in every selected byte. A 4-byte identifier read gives 0xFFFFFFFF.
- R10: Any other I/O address, and any access to 0x0CF8 whose size is not 4, is acknowledged next cycle. A read returns 0xFFFFFFFF, and a write leaves the address register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_req | input | 1 | One-cycle I/O access strobe |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 3 | Access size in bytes |
| io_wdata | input | 32 | I/O write data, low-aligned |
| io_ack | output | 1 | One-cycle access completion |
| io_rdata | output | 32 | Read data, valid with io_ack |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus |
| cfg_dev | output | 5 | Target device |
| cfg_func | output | 3 | Target function |
| cfg_reg | output | 6 | Target dword index |
| cfg_be | output | 4 | Byte enables within the dword |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_ready | input | 1 | Responder accepts and completes |
| cfg_rdata | input | 32 | Response data, valid with cfg_ready |

## Verification
A corrupted address register shows at the ports in one of two ways. The next readback of 0x0CF8 returns the wrong value, or the next window access carries the wrong bus, device, function or index fields. In both cases the fault appears on the cycle after the request. A wrong lane or size latch shows up as a wrong byte enable immediately, or as misaligned read data on the acknowledge that follows the handshake. A stuck request flag shows within a cycle as a missing or extra acknowledge, or as swallowed I/O strobes. The bench compares every cycle against a behavioural model, so each of these faults is reported on the first cycle it reaches a port.

// File: rtl/pci_cfg_port_bridge.sv
module pci_cfg_port_bridge #(
  parameter logic [15:0] ADDR_PORT = 16'h0CF8,
  parameter logic [15:0] DATA_BASE = 16'h0CFC
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_req,
  input  logic        io_wr,
  input  logic [15:0] io_addr,
  input  logic [2:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic        io_ack,
  output logic [31:0] io_rdata,
  output logic        cfg_valid,
  output logic        cfg_write,
  output logic [7:0]  cfg_bus,
  output logic [4:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [5:0]  cfg_reg,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic        cfg_ready,
  input  logic [31:0] cfg_rdata
);

  logic [31:0] addr_q;
  logic [1:0]  lane_q;
  logic [3:0]  mask_q;
  logic [3:0]  mask;

  wire [1:0] lane     = io_addr[1:0];
  wire       hit_addr = (io_addr == ADDR_PORT) && (io_size == 3'd4);
  wire       hit_win  = (io_addr[15:2] == DATA_BASE[15:2]);
  wire       size_ok  = (io_size == 3'd1) ||
                        (io_size == 3'd2 && !lane[0]) ||
                        (io_size == 3'd4 && lane == 2'd0);
  wire       go_cfg   = hit_win && size_ok && addr_q[31];

  always_comb begin
    case (io_size)
      3'd1:    mask = 4'b0001;
      3'd2:    mask = 4'b0011;
      default: mask = 4'b1111;
    endcase
  end

  wire [31:0] shifted = cfg_rdata >> {lane_q, 3'b000};
  wire [31:0] keep    = {{8{mask_q[3]}}, {8{mask_q[2]}}, {8{mask_q[1]}}, {8{mask_q[0]}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      lane_q    <= '0;
      mask_q    <= '0;
      io_ack    <= 1'b0;
      io_rdata  <= '0;
      cfg_valid <= 1'b0;
      cfg_write <= 1'b0;
      cfg_bus   <= '0;
      cfg_dev   <= '0;
      cfg_func  <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_wdata <= '0;
    end else begin
      io_ack <= 1'b0;
      if (cfg_valid) begin
        if (cfg_ready) begin
          cfg_valid <= 1'b0;
          io_ack    <= 1'b1;
          io_rdata  <= shifted & keep;
        end
      end else if (io_req) begin
        if (go_cfg) begin
          cfg_valid <= 1'b1;
          cfg_write <= io_wr;
          cfg_bus   <= addr_q[23:16];
          cfg_dev   <= addr_q[15:11];
          cfg_func  <= addr_q[10:8];
          cfg_reg   <= addr_q[7:2];
          cfg_be    <= mask << lane;
          cfg_wdata <= io_wdata << {lane, 3'b000};
          lane_q    <= lane;
          mask_q    <= mask;
        end else begin
          io_ack   <= 1'b1;
          io_rdata <= (hit_addr && !io_wr) ? addr_q : 32'hFFFF_FFFF;
          if (hit_addr && io_wr) addr_q <= io_wdata;
        end
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_be) && $stable(cfg_reg) &&
                                $stable(cfg_bus) && $stable(cfg_wdata)); // R3
  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> (cfg_be inside {4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF})); // R4
  AST_ACK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && cfg_ready |=> io_ack && !cfg_valid); // R5
  AST_BAD_SIZE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !cfg_valid && hit_win && !size_ok |=> io_ack && !cfg_valid); // R6
  AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !cfg_valid && !addr_q[31] |=> io_ack && !cfg_valid); // R7
  AST_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && cfg_valid && !cfg_ready |=> $stable(addr_q) && !io_ack); // R8

endmodule

// File: tb/pci_cfg_port_bridge_tb.sv
module pci_cfg_port_bridge_tb_top;
  logic clk = 0, rst_n = 0;
  logic io_req = 0, io_wr = 0;
  logic [15:0] io_addr = 0;
  logic [2:0] io_size = 4;
  logic [31:0] io_wdata = 0;
  logic io_ack, cfg_valid, cfg_write;
  logic [31:0] io_rdata, cfg_wdata, cfg_rdata;
  logic [7:0] cfg_bus;
  logic [4:0] cfg_dev;
  logic [2:0] cfg_func;
  logic [5:0] cfg_reg;
  logic [3:0] cfg_be;
  logic cfg_ready = 0;

  always #2 clk = ~clk;

  pci_cfg_port_bridge dut_i (.*);

  function automatic logic [31:0] resp(input logic [7:0] b, input logic [4:0] d,
                                       input logic [2:0] f, input logic [5:0] r);
    if (d == 5'd31) return 32'hFFFF_FFFF;
    return {b, d, f, r, 2'b01, 8'hA5};
  endfunction
  assign cfg_rdata = resp(cfg_bus, cfg_dev, cfg_func, cfg_reg);

  int checks = 0, fails = 0, cyc = 0;
  bit ready_hold = 0;
  string tag = "R1";

  logic [31:0] m_addr, m_rd, m_wd;
  bit m_pend, m_ack, m_wr, m_rdv;
  int m_lane, m_size;
  logic [7:0] m_bus; logic [4:0] m_dev; logic [2:0] m_func; logic [5:0] m_reg;
  logic [3:0] m_be;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_addr = 0; m_pend = 0; m_ack = 0; m_rdv = 0;
    end else if (m_pend) begin
      m_ack = 0;
      if (cfg_ready) begin
        logic [31:0] r;
        r = resp(m_bus, m_dev, m_func, m_reg) >> (8 * m_lane);
        if (m_size == 1) r = r & 32'hFF;
        else if (m_size == 2) r = r & 32'hFFFF;
        m_pend = 0; m_ack = 1; m_rdv = !m_wr; m_rd = r;
      end
    end else begin
      m_ack = 0;
      if (io_req) begin
        int ln;
        bit legal;
        ln = io_addr[1:0];
        legal = (io_size == 1) || (io_size == 2 && ln % 2 == 0) || (io_size == 4 && ln == 0);
        if (io_addr >= 16'h0CFC && io_addr <= 16'h0CFF && legal && m_addr[31]) begin
          m_pend = 1; m_wr = io_wr; m_lane = ln; m_size = io_size;
          m_bus = m_addr[23:16]; m_dev = m_addr[15:11]; m_func = m_addr[10:8]; m_reg = m_addr[7:2];
          m_be = (io_size == 1 ? 4'h1 : io_size == 2 ? 4'h3 : 4'hF) << ln;
          m_wd = io_wdata << (8 * ln);
        end else begin
          m_ack = 1; m_rdv = !io_wr;
          if (io_addr == 16'h0CF8 && io_size == 4) begin
            if (io_wr) m_addr = io_wdata; else m_rd = m_addr;
          end else m_rd = 32'hFFFF_FFFF;
        end
      end
    end
  end

  task automatic chk(input string t, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    cfg_ready <= !ready_hold && (cyc % 3 == 1);
    chk(tag, "io_ack", 32'(io_ack), 32'(m_ack));
    chk(tag, "cfg_valid", 32'(cfg_valid), 32'(m_pend));
    if (m_ack && m_rdv) chk(tag, "io_rdata", io_rdata, m_rd);
    if (m_pend) begin
      chk("R3", "cfg fields", {cfg_bus, cfg_dev, cfg_func, cfg_reg, 9'(cfg_write)},
          {m_bus, m_dev, m_func, m_reg, 9'(m_wr)});
      chk("R4", "cfg_be", 32'(cfg_be), 32'(m_be));
      if (m_wr) chk("R4", "cfg_wdata", cfg_wdata, m_wd);
    end
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic acc(input bit wr, input logic [15:0] a, input logic [2:0] sz,
                     input logic [31:0] d, input string t);
    @(negedge clk);
    tag = t; io_req = 1; io_wr = wr; io_addr = a; io_size = sz; io_wdata = d;
    @(negedge clk);
    io_req = 0;
    while (m_pend || m_ack) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    acc(0, 16'h0CF8, 4, 0, "R1");
    acc(1, 16'h0CF8, 4, 32'h8012_3A5B, "R2");
    acc(0, 16'h0CF8, 4, 0, "R2");
    acc(1, 16'h0CF8, 4, 32'h8005_1A14, "R3");
    acc(0, 16'h0CFC, 4, 0, "R5");
    acc(0, 16'h0CFE, 2, 0, "R5");
    acc(0, 16'h0CFD, 1, 0, "R5");
    acc(0, 16'h0CFF, 1, 0, "R5");
    acc(1, 16'h0CFC, 4, 32'hDEAD_BEEF, "R4");
    acc(1, 16'h0CFE, 2, 32'h0000_1234, "R4");
    acc(1, 16'h0CFB + 16'd4, 1, 32'h0000_0077, "R4");
    acc(0, 16'h0CFC, 3, 0, "R6");
    acc(0, 16'h0CFD, 2, 0, "R6");
    acc(0, 16'h0CFE, 4, 0, "R6");
    acc(1, 16'h0CFC, 0, 32'h5, "R6");
    acc(1, 16'h0CF8, 4, 32'h0000_F800, "R9");
    acc(1, 16'h0CF8, 4, 32'h8000_F800, "R9");
    acc(0, 16'h0CFC, 4, 0, "R9");
    acc(0, 16'h0CFE, 1, 0, "R9");
    acc(1, 16'h0CF8, 2, 32'h0, "R10");
    acc(0, 16'h0CF9, 1, 0, "R10");
    acc(0, 16'h0080, 4, 0, "R10");
    acc(0, 16'h0CF8, 4, 0, "R10");
    acc(1, 16'h0CF8, 4, 32'h8022_4308, "R8");
    ready_hold = 1;
    @(negedge clk);
    tag = "R8"; io_req = 1; io_wr = 0; io_addr = 16'h0CFC; io_size = 4;
    @(negedge clk);
    io_wr = 1; io_addr = 16'h0CF8; io_wdata = 32'h0;
    repeat (3) @(negedge clk);
    io_req = 0;
    ready_hold = 0;
    while (m_pend || m_ack) @(negedge clk);
    acc(0, 16'h0CF8, 4, 0, "R8");
    acc(1, 16'h0CF8, 4, 32'h0, "R7");
    acc(0, 16'h0CFC, 4, 0, "R7");
    acc(1, 16'h0CFE, 2, 32'hAAAA, "R7");
    acc(0, 16'h0CFF, 1, 0, "R7");
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule